// File: doc/BRIEF.md
# SPI Flash Transaction Engine

This block is a register-programmed SPI master that runs one serial flash transaction at a time. Software fills a command word, which holds an opcode byte and three address bytes, and a data word. It then writes a control word that gives the number of bytes to send and the number of bytes to read back, and sets a go bit. The engine asserts one of two chip selects and shifts out 1 to 8 bytes, MSB first, in SPI mode 0. Each byte comes from a fixed byte lane of the command and data words. The engine then clocks in 0 to 8 bytes and writes each one into a fixed byte lane of the same two words. Software polls a busy flag until the transfer ends and then reads the results.

The SCK rate is the system clock divided by 2, 4, 8 or 16, chosen by a 2-bit rate field. A 2-bit address-size override field is stored and reported back. When it is in automatic mode, the engine reports 24-bit addressing.

Top module: `spi_xact_engine`

## Requirements
- R1: After reset the control word reads 0x0002_0000 (counts 0, select 0, busy 0, override 0, size field 18:17 = 1), the rate word at 0x1C reads 0x0003_0000, both chip selects are high and SCK is low.
- R2: A write to offset 0x00 with bit 8 set and legal counts starts a transaction while the engine is idle. Bit 16 (busy) reads 1 from the next cycle on, and bit 8 always reads 0.
- R3: The transmit bytes are sent MSB first in this order: command[7:0], command[31:24], command[23:16], command[15:8], data[7:0], data[15:8], data[23:16], data[31:24]. The count in control bits 3:0 sets how many are sent. MOSI changes only while SCK is low.
- R4: Received byte r (counted from 0) is stored in data lane r for r < 4, and in command lane r-4 for r >= 4. Lane n means bits 8n+7:8n. The count in control bits 7:4 sets how many bytes are received. Lanes that are not written keep their values.
- R5: Control bit 9 = 0 drives chip select 0 low for the transaction, and bit 9 = 1 drives chip select 1 low. The other select stays high, and no more than one select is ever low.
- R6: SCK idles low, and its period is 2^(d+1) system clocks, where d is the value in rate bits 17:16. A transaction gives exactly 8*(tx+rx) rising edges.
- R7: Busy falls and both selects go high after the last falling SCK edge. Busy is 1 exactly while a chip select is low.
- R8: While busy, bus writes to the control, command, data and rate words have no effect.
- R9: A start write with transmit count 0, transmit count above 8 or receive count above 8 does not start a transaction.
- R10: Control bits 20:19 store the size override. Bits 18:17 read 0 when the override is 1 (16-bit) and 1 otherwise (24-bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read enable; read data is combinational |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when bus_rd is low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 2 | Active-low chip selects |

## Verification
Two things can land on the command and data words in the same cycle: a software write and a received byte captured from MISO. The design settles this by dropping every software write while a transaction runs. The bench provokes the collision by issuing writes to all four words, with random values and fresh start bits, in the middle of transfers. It then compares the whole contents of both words, the rate word and the control word against a model that stores only the received bytes. Random transfers also vary the transmit and receive counts, the rate, the chip select and the flash reply. Each one is scored on the captured MOSI bits, the SCK edge count and period, and select exclusivity.

// File: rtl/spi_xact_pkg.sv
package spi_xact_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned LANES     = REG_W / 8;
  localparam int unsigned MAX_BYTES = 2 * LANES;
  localparam int unsigned IDX_W     = $clog2(MAX_BYTES);
  localparam int unsigned CNT_W     = 4;
  localparam int unsigned DIV_W     = 2;
  localparam int unsigned BIT_W     = $clog2(MAX_BYTES * 16);

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_CMD  = 8'h04;
  localparam logic [7:0] OFS_DATA = 8'h08;
  localparam logic [7:0] OFS_RATE = 8'h1C;

  localparam int unsigned CTL_RX_LSB   = 4;
  localparam int unsigned CTL_GO       = 8;
  localparam int unsigned CTL_SEL      = 9;
  localparam int unsigned CTL_BUSY     = 16;
  localparam int unsigned CTL_SIZE_LSB = 17;
  localparam int unsigned CTL_OVR_LSB  = 19;
  localparam int unsigned RATE_LSB     = 16;

  typedef enum logic {ST_IDLE, ST_SHIFT} eng_state_e;

  // Byte that goes out on the wire in position idx of the transmit phase.
  function automatic logic [7:0] tx_lane(input logic [REG_W-1:0] cmd,
                                         input logic [REG_W-1:0] dat,
                                         input logic [IDX_W-1:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0:    b = cmd[7:0];
      3'd1:    b = cmd[31:24];
      3'd2:    b = cmd[23:16];
      3'd3:    b = cmd[15:8];
      3'd4:    b = dat[7:0];
      3'd5:    b = dat[15:8];
      3'd6:    b = dat[23:16];
      default: b = dat[31:24];
    endcase
    return b;
  endfunction
endpackage

// File: rtl/spi_xact_clkgen.sv
module spi_xact_clkgen
  import spi_xact_pkg::*;
#(
  parameter int unsigned RW = DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [RW-1:0] rate,
  output logic          tick
);
  localparam int unsigned CW = 2 ** RW;

  logic [CW-1:0] cnt_q, cnt_n, lim;

  always_comb begin
    lim  = ({{(CW-1){1'b0}}, 1'b1} << rate) - 1'b1;
    tick = run && (cnt_q == lim);
    if (!run || tick) cnt_n = '0;
    else              cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/spi_xact_shifter.sv
module spi_xact_shifter
  import spi_xact_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          tick,
  input  logic [CNT_W-1:0]              tx_cnt,
  input  logic [CNT_W-1:0]              rx_cnt,
  input  logic                          sel,
  input  logic [MAX_BYTES-1:0][7:0]     tx_bytes,
  input  logic                          miso,
  output logic                          busy,
  output logic                          sck,
  output logic                          mosi,
  output logic [1:0]                    cs_n,
  output logic                          rx_push,
  output logic [IDX_W-1:0]              rx_idx,
  output logic [7:0]                    rx_byte
);
  eng_state_e       st_q, st_n;
  logic [BIT_W-1:0] bit_q, bit_n, last_bit;
  logic             sck_q, sck_n;
  logic [6:0]       sh_q, sh_n;
  logic [CNT_W:0]   byte_tot;
  logic [CNT_W-1:0] byte_idx;
  logic             in_tx;

  always_comb begin
    byte_tot = {1'b0, tx_cnt} + {1'b0, rx_cnt};
    last_bit = BIT_W'({byte_tot - 1'b1, 3'b111});
    byte_idx = CNT_W'(bit_q[BIT_W-1:3]);
    in_tx    = byte_idx < tx_cnt;
    busy     = (st_q == ST_SHIFT);
    sck      = sck_q;
    mosi     = busy && in_tx && tx_bytes[byte_idx[IDX_W-1:0]][~bit_q[2:0]];
    cs_n     = busy ? (sel ? 2'b01 : 2'b10) : 2'b11;
    rx_idx   = IDX_W'(byte_idx - tx_cnt);
    rx_byte  = {sh_q, miso};
    rx_push  = busy && tick && !sck_q && !in_tx && (bit_q[2:0] == 3'd7);
  end

  always_comb begin
    st_n  = st_q;
    bit_n = bit_q;
    sck_n = sck_q;
    sh_n  = sh_q;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_n  = ST_SHIFT;
          bit_n = '0;
          sck_n = 1'b0;
        end
      end
      default: begin
        if (tick) begin
          if (!sck_q) begin
            sck_n = 1'b1;
            if (!in_tx) sh_n = {sh_q[5:0], miso};
          end else begin
            sck_n = 1'b0;
            if (bit_q == last_bit) st_n  = ST_IDLE;
            else                   bit_n = bit_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      bit_q <= '0;
      sck_q <= 1'b0;
      sh_q  <= '0;
    end else begin
      st_q  <= st_n;
      bit_q <= bit_n;
      sck_q <= sck_n;
      sh_q  <= sh_n;
    end
  end
endmodule

// File: rtl/spi_xact_regs.sv
module spi_xact_regs
  import spi_xact_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              busy,
  input  logic              rx_push,
  input  logic [IDX_W-1:0]  rx_idx,
  input  logic [7:0]        rx_byte,
  output logic [REG_W-1:0]  cmd_q,
  output logic [REG_W-1:0]  dat_q,
  output logic [CNT_W-1:0]  tx_cnt_q,
  output logic [CNT_W-1:0]  rx_cnt_q,
  output logic              sel_q,
  output logic [DIV_W-1:0]  rate_q,
  output logic              start
);
  logic [REG_W-1:0] cmd_n, dat_n, ctl_rd;
  logic [CNT_W-1:0] tx_n, rx_n, tx_w, rx_w;
  logic             sel_n;
  logic [1:0]       ovr_q, ovr_n, size_rd;
  logic [DIV_W-1:0] rate_n;
  logic             wr_ok, hit_ctl, hit_cmd, hit_dat, hit_rate, cnt_ok;

  always_comb begin
    wr_ok    = bus_wr && !busy;
    hit_ctl  = wr_ok && (bus_addr == ADDR_W'(OFS_CTRL));
    hit_cmd  = wr_ok && (bus_addr == ADDR_W'(OFS_CMD));
    hit_dat  = wr_ok && (bus_addr == ADDR_W'(OFS_DATA));
    hit_rate = wr_ok && (bus_addr == ADDR_W'(OFS_RATE));
    tx_w     = bus_wdata[CNT_W-1:0];
    rx_w     = bus_wdata[CTL_RX_LSB +: CNT_W];
    cnt_ok   = (tx_w != '0) && (tx_w <= CNT_W'(MAX_BYTES)) && (rx_w <= CNT_W'(MAX_BYTES));
    start    = hit_ctl && bus_wdata[CTL_GO] && cnt_ok;

    cmd_n  = hit_cmd ? bus_wdata : cmd_q;
    dat_n  = hit_dat ? bus_wdata : dat_q;
    tx_n   = hit_ctl ? tx_w : tx_cnt_q;
    rx_n   = hit_ctl ? rx_w : rx_cnt_q;
    sel_n  = hit_ctl ? bus_wdata[CTL_SEL] : sel_q;
    ovr_n  = hit_ctl ? bus_wdata[CTL_OVR_LSB +: 2] : ovr_q;
    rate_n = hit_rate ? bus_wdata[RATE_LSB +: DIV_W] : rate_q;

    if (rx_push) begin
      if (!rx_idx[IDX_W-1]) dat_n[8*rx_idx[IDX_W-2:0] +: 8] = rx_byte;
      else                  cmd_n[8*rx_idx[IDX_W-2:0] +: 8] = rx_byte;
    end
  end

  always_comb begin
    size_rd = (ovr_q == 2'd1) ? 2'd0 : 2'd1;
    ctl_rd  = '0;
    ctl_rd[CNT_W-1:0]              = tx_cnt_q;
    ctl_rd[CTL_RX_LSB +: CNT_W]    = rx_cnt_q;
    ctl_rd[CTL_SEL]                = sel_q;
    ctl_rd[CTL_BUSY]               = busy;
    ctl_rd[CTL_SIZE_LSB +: 2]      = size_rd;
    ctl_rd[CTL_OVR_LSB +: 2]       = ovr_q;
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == ADDR_W'(OFS_CTRL))      bus_rdata = ctl_rd;
      else if (bus_addr == ADDR_W'(OFS_CMD))  bus_rdata = cmd_q;
      else if (bus_addr == ADDR_W'(OFS_DATA)) bus_rdata = dat_q;
      else if (bus_addr == ADDR_W'(OFS_RATE)) bus_rdata[RATE_LSB +: DIV_W] = rate_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      dat_q    <= '0;
      tx_cnt_q <= '0;
      rx_cnt_q <= '0;
      sel_q    <= 1'b0;
      ovr_q    <= 2'd0;
      rate_q   <= '1;
    end else begin
      cmd_q    <= cmd_n;
      dat_q    <= dat_n;
      tx_cnt_q <= tx_n;
      rx_cnt_q <= rx_n;
      sel_q    <= sel_n;
      ovr_q    <= ovr_n;
      rate_q   <= rate_n;
    end
  end
endmodule

// File: rtl/spi_xact_engine.sv
module spi_xact_engine
  import spi_xact_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [1:0]        spi_cs_n
);
  logic [REG_W-1:0]          cmd_q, dat_q;
  logic [CNT_W-1:0]          tx_cnt, rx_cnt;
  logic                      sel, start, busy, tick, rx_push;
  logic [DIV_W-1:0]          rate;
  logic [IDX_W-1:0]          rx_idx;
  logic [7:0]                rx_byte;
  logic [MAX_BYTES-1:0][7:0] tx_bytes;

  for (genvar i = 0; i < MAX_BYTES; i++) begin : g_lane
    assign tx_bytes[i] = tx_lane(cmd_q, dat_q, IDX_W'(i));
  end

  spi_xact_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .rx_push(rx_push), .rx_idx(rx_idx), .rx_byte(rx_byte),
    .cmd_q(cmd_q), .dat_q(dat_q), .tx_cnt_q(tx_cnt), .rx_cnt_q(rx_cnt),
    .sel_q(sel), .rate_q(rate), .start(start)
  );

  spi_xact_clkgen #(.RW(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy), .rate(rate), .tick(tick)
  );

  spi_xact_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .sel(sel), .tx_bytes(tx_bytes),
    .miso(spi_miso), .busy(busy), .sck(spi_sck), .mosi(spi_mosi),
    .cs_n(spi_cs_n), .rx_push(rx_push), .rx_idx(rx_idx), .rx_byte(rx_byte)
  );
endmodule

// File: rtl/spi_xact_engine_chk.sv
module spi_xact_engine_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic              spi_sck,
  input logic              spi_mosi,
  input logic [1:0]        spi_cs_n,
  input logic              busy
);
  logic ctl_wr, good_cnt;
  assign ctl_wr   = bus_wr && (bus_addr == ADDR_W'(0));
  assign good_cnt = (bus_wdata[3:0] != 4'd0) && (bus_wdata[3:0] <= 4'd8) &&
                    (bus_wdata[7:4] <= 4'd8);

  p_one_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~spi_cs_n) <= 1);

  p_select_tracks_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (spi_cs_n != 2'b11));

  p_sck_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sck);

  p_go_sets_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ctl_wr && bus_wdata[8] && good_cnt) |=> busy);

  p_bad_count_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ctl_wr && !good_cnt) |=> !busy);

  p_select_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(spi_cs_n));

  p_mosi_hold_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));
endmodule

bind spi_xact_engine spi_xact_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
  .spi_cs_n(spi_cs_n), .busy(busy)
);

// File: tb/spi_xact_engine_test.sv
`timescale 1ns/1ps
module spi_xact_engine_test;
  logic        clk, rst_n, bus_wr, bus_rd, spi_sck, spi_mosi, spi_miso;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [1:0]  spi_cs_n;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // flash model state
  int k = 0, edges = 0, cur_tx = 0;
  logic [7:0] rb [8];
  logic [127:0] cap;
  realtime t0, t1;
  bit sel_seen, other_low;
  int watch_sel;

  spi_xact_engine uut (.*);

  initial clk = 0;
  always #2.5 clk = ~clk;

  always_comb begin
    int kb;
    kb = k / 8;
    spi_miso = 1'b0;
    if (kb >= cur_tx && kb < 16) spi_miso = rb[(kb - cur_tx) & 7][7 - (k % 8)];
  end

  always @(posedge spi_sck) begin
    if (k < 128) cap[k] = spi_mosi;
    if (k == 0) t0 = $realtime;
    if (k == 1) t1 = $realtime;
    k = k + 1;
    edges = edges + 1;
  end

  always @(negedge clk) begin
    if (spi_cs_n[watch_sel] == 1'b0) sel_seen = 1;
    if (spi_cs_n[1-watch_sel] == 1'b0) other_low = 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    bus_rd = 0;
  endtask

  function automatic logic [7:0] xb(input logic [31:0] c, input logic [31:0] d, input int i);
    case (i)
      0: return c[7:0];
      1: return c[31:24];
      2: return c[23:16];
      3: return c[15:8];
      default: return d[8*(i-4) +: 8];
    endcase
  endfunction

  task automatic wait_idle(output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      rd(8'h00, v);
      if (!v[16]) begin ok = 1; break; end
    end
  endtask

  task automatic xact(input int tx, input int rx, input int dv, input bit sel,
                      input int ovr, input bit hammer);
    logic [31:0] cmd, dat, ecmd, edat, v, ctl;
    bit ok;
    int bad;
    cmd = $urandom; dat = $urandom;
    for (int i = 0; i < 8; i++) rb[i] = 8'($urandom);
    wr(8'h1C, 32'(dv) << 16);
    wr(8'h04, cmd);
    wr(8'h08, dat);
    k = 0; edges = 0; cur_tx = tx; cap = '0;
    watch_sel = sel; sel_seen = 0; other_low = 0;
    ctl = 32'(tx) | (32'(rx) << 4) | (32'(sel) << 9) | (32'(ovr) << 19);
    wr(8'h00, ctl | 32'h100);
    rd(8'h00, v);
    chk(v[16] == 1'b1 && v[8] == 1'b0, "R2 busy after go", v, ctl | 32'h10000);
    if (hammer) begin
      wr(8'h04, $urandom);
      wr(8'h08, $urandom);
      wr(8'h00, 32'h0000_0188 ^ 32'(sel) << 9);
      wr(8'h1C, 32'($urandom) & 32'h0003_0000);
    end
    wait_idle(ok);
    chk(ok, "R7 busy clears", 32'(ok), 1);
    rd(8'h00, v);
    chk(v == (ctl | (32'(ovr != 1) << 17)), "R8/R10 control readback", v,
        ctl | (32'(ovr != 1) << 17));
    rd(8'h1C, v);
    chk(v == 32'(dv) << 16, "R8 rate kept", v, 32'(dv) << 16);
    chk(spi_cs_n == 2'b11 && spi_sck == 1'b0, "R7 pins idle", {30'b0, spi_cs_n}, 3);
    bad = 0;
    for (int i = 0; i < tx * 8; i++)
      if (cap[i] !== xb(cmd, dat, i / 8)[7 - i % 8]) bad++;
    chk(bad == 0, "R3 mosi bytes", bad, 0);
    chk(edges == 8 * (tx + rx), "R6 sck edges", edges, 8 * (tx + rx));
    chk((t1 - t0) == 5.0 * (2 ** (dv + 1)), "R6 sck period", int'(t1 - t0),
        5 * (2 ** (dv + 1)));
    chk(sel_seen && !other_low, "R5 chip select", {sel_seen, other_low}, 2);
    ecmd = cmd; edat = dat;
    for (int r = 0; r < rx; r++)
      if (r < 4) edat[8*r +: 8] = rb[r];
      else       ecmd[8*(r-4) +: 8] = rb[r];
    rd(8'h08, v);
    chk(v == edat, "R4 data word", v, edat);
    rd(8'h04, v);
    chk(v == ecmd, "R4 command word", v, ecmd);
  endtask

  task automatic bad_start(input logic [31:0] ctl);
    logic [31:0] v;
    edges = 0;
    wr(8'h00, ctl | 32'h100);
    repeat (20) @(negedge clk);
    rd(8'h00, v);
    chk(v[16] == 0 && edges == 0 && spi_cs_n == 2'b11, "R9 illegal count", v, ctl & 32'hff);
    chk(v[7:0] == ctl[7:0], "R9 counts stored", v, ctl & 32'hff);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000 && !done) begin
        done = 1;
        n_chk++; n_bad++;
        $display("FAIL watchdog act=%0d exp=<190000", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed_1234));
    bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0; watch_sel = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(8'h00, v);
    chk(v == 32'h0002_0000, "R1 control reset", v, 32'h0002_0000);
    rd(8'h1C, v);
    chk(v == 32'h0003_0000, "R1 rate reset", v, 32'h0003_0000);
    chk(spi_cs_n == 2'b11 && spi_sck == 0, "R1 pins reset", {30'b0, spi_cs_n}, 3);

    // directed corners
    xact(1, 0, 0, 0, 0, 0);
    xact(8, 0, 1, 1, 2, 1);
    xact(1, 8, 0, 0, 1, 1);
    xact(4, 4, 3, 1, 0, 0);
    xact(2, 1, 2, 0, 3, 0);
    xact(5, 8, 0, 1, 1, 0);
    bad_start(32'h0000_0000);
    bad_start(32'h0000_0009);
    bad_start(32'h0000_0091);
    wr(8'h00, 32'h0008_0000);
    rd(8'h00, v);
    chk(v[18:17] == 2'd0 && v[20:19] == 2'd1, "R10 force 16-bit", v, 32'h0008_0000);
    wr(8'h00, 32'h0010_0000);
    rd(8'h00, v);
    chk(v[18:17] == 2'd1 && v[20:19] == 2'd2, "R10 force 24-bit", v, 32'h0012_0000);

    // random mix
    for (int n = 0; n < 30; n++)
      xact(1 + $urandom_range(0, 7), $urandom_range(0, 8), $urandom_range(0, 1),
           1'($urandom), $urandom_range(0, 3), 1'($urandom));

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule